// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator with Flag and Interrupt

This block holds a programmable alarm time and compares it with the current BCD time, which a separate counter chain supplies. The fields are month, date, hour, minute and second. Each field has its own ignore bit. Together the five ignore bits form a repeat code that sets how often the alarm fires. The supported codes run from one exact moment up to every second. Any code outside that set falls back to firing on every tick, so a bad setting is noticed quickly.

The comparison runs only on the one-second tick. A hit raises a sticky alarm flag. When the interrupt enable is set, the hit also pulls an active-low interrupt line. While the system runs from its backup supply, the line is driven only if a second enable for backup operation is also set. Software acknowledges in two reads of the flags byte. The first read releases the interrupt line and the second read clears the flag. A new hit in the same cycle as a clearing read wins over the clear.

Top module: `alarm_repeat_irq`

## Requirements
- R1: After reset the flag is 0, `irq_n` is 1, and both the interrupt enable and the backup enable are 0.
- R2: The alarm values are written at addresses 2 (second), 3 (minute), 4 (hour), 5 (date) and 6 (month). Bits [6:0] hold the BCD value. Bit 7 is the ignore bit of that field, and a 1 means the field is left out of the match.
- R3: With the repeat code 00000 (month ignore bit first, second ignore bit last), a hit needs all five fields equal to the time inputs. A mismatch in any one field gives no hit.
- R4: With the thermometer codes 10000, 11000, 11100 and 11110, only the fields whose ignore bit is 0 are compared.
- R5: With code 11111, or with any code that is not one of the six supported codes, every tick is a hit regardless of the time inputs.
- R6: The flag is set only on a cycle where `tick_1hz` is high and the match holds. Matching time with no tick sets nothing.
- R7: Address 7 bit 0 is the interrupt enable and bit 1 is the backup enable. When a hit occurs with the interrupt enable set and `on_battery` low, `irq_n` goes low on the next cycle.
- R8: With the interrupt enable clear, a hit sets only the flag and `irq_n` stays high.
- R9: While `on_battery` is high, a hit drives `irq_n` low only if both enables are set. Otherwise only the flag is set.
- R10: The flag appears at bit 6 of `flags`, and all other bits read 0. A `flags_rd` pulse while the interrupt is asserted releases `irq_n` and keeps the flag. A `flags_rd` pulse while the interrupt is released clears the flag.
- R11: When a hit and a `flags_rd` pulse fall in the same cycle, the flag stays set and the interrupt is asserted or kept according to R7 and R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| time_sec | input | 8 | Current second, BCD |
| time_min | input | 8 | Current minute, BCD |
| time_hour | input | 8 | Current hour, BCD (24 h) |
| time_date | input | 8 | Current date, BCD |
| time_month | input | 8 | Current month, BCD |
| on_battery | input | 1 | High while on the backup supply |
| flags_rd | input | 1 | One-cycle pulse marking a read of the flags byte |
| flags | output | 8 | Flags byte, alarm flag at bit 6 |
| irq_n | output | 1 | Active-low alarm interrupt |

## Verification
The bench builds the block with its default parameters: 8-bit fields, a 3-bit address and a register base of 2. These keep every field's ignore bit and the control address within one byte-wide write port. With them the bench can reach each supported repeat code, an unsupported code and both enable combinations under backup power. It also reaches the same-cycle race between a hit and a clearing read. Each field is driven with a mismatch on its own, so a compare that drops one field shows up as a false hit.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int ALM_FIELDS = 5;   // second, minute, hour, date, month
  localparam int ALM_DW     = 8;

  typedef logic [ALM_FIELDS-1:0] ign_t;

  // Thermometer codes filled from the month end are supported; others mean "ignore all".
  function automatic ign_t effective_ignore(input ign_t code);
    logic ok;
    ok = 1'b0;
    for (int k = 0; k <= ALM_FIELDS; k++) begin
      if (code == ~({ALM_FIELDS{1'b1}} >> k)) ok = 1'b1;
    end
    return ok ? code : {ALM_FIELDS{1'b1}};
  endfunction

  // BCD field equality, stored value carries its ignore bit in the MSB.
  function automatic logic field_equal(input logic [ALM_DW-1:0] now_v,
                                       input logic [ALM_DW-1:0] set_v);
    return now_v == {1'b0, set_v[ALM_DW-2:0]};
  endfunction
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs #(
  parameter int AW        = 3,
  parameter int DW        = 8,
  parameter int NF        = 5,
  parameter int BASE_ADDR = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [DW-1:0]        wr_data,
  output logic [NF-1:0][DW-1:0] alarm_set,
  output logic                 irq_en,
  output logic                 bak_en
);
  localparam int CTRL_ADDR = BASE_ADDR + NF;

  for (genvar i = 0; i < NF; i++) begin : g_field
    always_ff @(posedge clk) begin
      if (!rst_n)
        alarm_set[i] <= '0;
      else if (wr_en && wr_addr == AW'(BASE_ADDR + i))
        alarm_set[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_en <= 1'b0;
      bak_en <= 1'b0;
    end else if (wr_en && wr_addr == AW'(CTRL_ADDR)) begin
      irq_en <= wr_data[0];
      bak_en <= wr_data[1];
    end
  end

  AST_EN_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (!irq_en && !bak_en)); // R1
endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import alarm_pkg::*;
#(
  parameter int DW = 8,
  parameter int NF = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic [NF-1:0][DW-1:0] time_now,
  input  logic [NF-1:0][DW-1:0] alarm_set,
  output logic                  hit_evt,
  output logic [NF-1:0]         ignore_eff
);
  logic [NF-1:0] code;
  logic [NF-1:0] field_ok;

  for (genvar i = 0; i < NF; i++) begin : g_cmp
    assign code[i]     = alarm_set[i][DW-1];
    assign field_ok[i] = ignore_eff[i] | field_equal(time_now[i], alarm_set[i]);
  end

  assign ignore_eff = effective_ignore(code);
  assign hit_evt    = tick & (&field_ok);

  AST_ALL_IGNORED_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (&ignore_eff)) |-> hit_evt); // R5
  AST_HIT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |-> tick); // R6
endmodule

// File: rtl/alarm_flag_irq.sv
module alarm_flag_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_evt,
  input  logic rd_evt,
  input  logic irq_en,
  input  logic bak_en,
  input  logic on_battery,
  output logic flag_q,
  output logic irq_q
);
  logic irq_allow;
  assign irq_allow = irq_en & (~on_battery | bak_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else if (hit_evt) begin
      flag_q <= 1'b1;
      if (irq_allow) irq_q <= 1'b1;
    end else if (rd_evt) begin
      if (irq_q) irq_q  <= 1'b0;
      else       flag_q <= 1'b0;
    end
  end

  AST_IRQ_IMPLIES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> flag_q); // R10
  AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> flag_q); // R6
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(irq_en)); // R8
  AST_BACKUP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_q) && $past(on_battery)) |-> $past(bak_en)); // R9
  AST_FIRST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && irq_q && !hit_evt) |=> (!irq_q && flag_q)); // R10
  AST_SECOND_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && !irq_q && !hit_evt) |=> !flag_q); // R10
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && hit_evt) |=> flag_q); // R11
endmodule

// File: rtl/alarm_repeat_irq.sv
module alarm_repeat_irq
  import alarm_pkg::*;
#(
  parameter int AW        = 3,
  parameter int DW        = ALM_DW,
  parameter int BASE_ADDR = 2,
  parameter int FLAG_BIT  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          tick_1hz,
  input  logic [DW-1:0] time_sec,
  input  logic [DW-1:0] time_min,
  input  logic [DW-1:0] time_hour,
  input  logic [DW-1:0] time_date,
  input  logic [DW-1:0] time_month,
  input  logic          on_battery,
  input  logic          flags_rd,
  output logic [DW-1:0] flags,
  output logic          irq_n
);
  localparam int NF = ALM_FIELDS;

  logic [NF-1:0][DW-1:0] alarm_set;
  logic [NF-1:0][DW-1:0] time_now;
  logic [NF-1:0]         ignore_eff;
  logic                  irq_en, bak_en, hit_evt, flag_q, irq_q;

  assign time_now = {time_month, time_date, time_hour, time_min, time_sec};

  alarm_regs #(.AW(AW), .DW(DW), .NF(NF), .BASE_ADDR(BASE_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .alarm_set(alarm_set), .irq_en(irq_en), .bak_en(bak_en));

  alarm_match #(.DW(DW), .NF(NF)) u_match (
    .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .time_now(time_now),
    .alarm_set(alarm_set), .hit_evt(hit_evt), .ignore_eff(ignore_eff));

  alarm_flag_irq u_flag (
    .clk(clk), .rst_n(rst_n), .hit_evt(hit_evt), .rd_evt(flags_rd),
    .irq_en(irq_en), .bak_en(bak_en), .on_battery(on_battery),
    .flag_q(flag_q), .irq_q(irq_q));

  always_comb begin
    flags           = '0;
    flags[FLAG_BIT] = flag_q;
  end
  assign irq_n = ~irq_q;

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (irq_n && flags == '0)); // R1
  AST_IRQ_FALLS_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_evt && irq_en && !on_battery) |=> !irq_n); // R7
endmodule

// File: tb/alarm_repeat_irq_bench.sv
module alarm_repeat_irq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       tick_1hz = 1'b0;
  logic [7:0] time_sec = '0, time_min = '0, time_hour = '0, time_date = '0, time_month = '0;
  logic       on_battery = 1'b0;
  logic       flags_rd = 1'b0;
  logic [7:0] flags;
  logic       irq_n;
  int         n_cmp = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  alarm_repeat_irq u_alarm_repeat_irq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tick_1hz(tick_1hz), .time_sec(time_sec), .time_min(time_min),
    .time_hour(time_hour), .time_date(time_date), .time_month(time_month),
    .on_battery(on_battery), .flags_rd(flags_rd), .flags(flags), .irq_n(irq_n));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // code bits: [4]=month .. [0]=second ignore
  task automatic set_alarm(input logic [4:0] code, input logic [7:0] mo, dt, hr, mi, se);
    wr(3'd2, {code[0], se[6:0]});
    wr(3'd3, {code[1], mi[6:0]});
    wr(3'd4, {code[2], hr[6:0]});
    wr(3'd5, {code[3], dt[6:0]});
    wr(3'd6, {code[4], mo[6:0]});
  endtask

  task automatic tick_at(input logic [7:0] mo, dt, hr, mi, se, input bit with_rd);
    time_month = mo; time_date = dt; time_hour = hr; time_min = mi; time_sec = se;
    tick_1hz = 1'b1; flags_rd = with_rd;
    @(negedge clk);
    tick_1hz = 1'b0; flags_rd = 1'b0;
  endtask

  task automatic rd_once();
    flags_rd = 1'b1;
    @(negedge clk);
    flags_rd = 1'b0;
  endtask

  task automatic clear_all();
    rd_once(); rd_once();
  endtask

  task automatic t_reset();
    chk("R1 flags", flags, 8'h00);
    chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
    // enables cleared: a hit right after reset must not assert irq
    set_alarm(5'b11111, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    tick_at(8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 1'b0);
    chk("R1 enables clear irq_n", {7'd0, irq_n}, 8'h01);
    chk("R1 R10 flag bit6", flags, 8'h40);
    clear_all();
  endtask

  task automatic t_exact();
    wr(3'd7, 8'h01);
    set_alarm(5'b00000, 8'h12, 8'h25, 8'h10, 8'h30, 8'h45);
    tick_at(8'h12, 8'h25, 8'h10, 8'h30, 8'h44, 1'b0);
    chk("R3 second differs", flags, 8'h00);
    tick_at(8'h12, 8'h25, 8'h11, 8'h30, 8'h45, 1'b0);
    chk("R3 hour differs", flags, 8'h00);
    tick_at(8'h11, 8'h25, 8'h10, 8'h30, 8'h45, 1'b0);
    chk("R3 month differs", flags, 8'h00);
    tick_at(8'h12, 8'h24, 8'h10, 8'h30, 8'h45, 1'b0);
    chk("R3 date differs", flags, 8'h00);
    tick_at(8'h12, 8'h25, 8'h10, 8'h31, 8'h45, 1'b0);
    chk("R3 minute differs", flags, 8'h00);
    tick_at(8'h12, 8'h25, 8'h10, 8'h30, 8'h45, 1'b0);
    chk("R3 exact hit flags", flags, 8'h40);
    chk("R7 irq low", {7'd0, irq_n}, 8'h00);
    rd_once();
    chk("R10 first read releases irq", {7'd0, irq_n}, 8'h01);
    chk("R10 first read keeps flag", flags, 8'h40);
    rd_once();
    chk("R10 second read clears flag", flags, 8'h00);
  endtask

  task automatic t_no_tick();
    time_month = 8'h12; time_date = 8'h25; time_hour = 8'h10; time_min = 8'h30; time_sec = 8'h45;
    repeat (3) @(negedge clk);
    chk("R6 no tick no flag", flags, 8'h00);
    chk("R6 no tick irq", {7'd0, irq_n}, 8'h01);
  endtask

  task automatic t_repeat();
    set_alarm(5'b10000, 8'h12, 8'h25, 8'h10, 8'h30, 8'h45);
    tick_at(8'h03, 8'h25, 8'h10, 8'h30, 8'h45, 1'b0);
    chk("R4 10000 month ignored", flags, 8'h40);
    clear_all();
    tick_at(8'h03, 8'h26, 8'h10, 8'h30, 8'h45, 1'b0);
    chk("R4 10000 date compared", flags, 8'h00);
    set_alarm(5'b11100, 8'h12, 8'h25, 8'h10, 8'h30, 8'h45);
    tick_at(8'h01, 8'h02, 8'h23, 8'h30, 8'h45, 1'b0);
    chk("R4 11100 hour ignored", flags, 8'h40);
    clear_all();
    set_alarm(5'b11110, 8'h12, 8'h25, 8'h10, 8'h30, 8'h45);
    tick_at(8'h01, 8'h02, 8'h03, 8'h04, 8'h45, 1'b0);
    chk("R2 R4 11110 second only hit", flags, 8'h40);
    clear_all();
    tick_at(8'h12, 8'h25, 8'h10, 8'h30, 8'h46, 1'b0);
    chk("R4 11110 second miss", flags, 8'h00);
  endtask

  task automatic t_fallback();
    set_alarm(5'b01000, 8'h12, 8'h25, 8'h10, 8'h30, 8'h45);
    tick_at(8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 1'b0);
    chk("R5 unsupported code fires", flags, 8'h40);
    clear_all();
    set_alarm(5'b11111, 8'h12, 8'h25, 8'h10, 8'h30, 8'h45);
    tick_at(8'h07, 8'h08, 8'h09, 8'h10, 8'h11, 1'b0);
    chk("R5 every second", flags, 8'h40);
    clear_all();
  endtask

  task automatic t_enables();
    wr(3'd7, 8'h00);
    tick_at(8'h01, 8'h01, 8'h01, 8'h01, 8'h01, 1'b0);
    chk("R8 flag only", flags, 8'h40);
    chk("R8 irq stays high", {7'd0, irq_n}, 8'h01);
    rd_once();
    chk("R10 read without irq clears flag", flags, 8'h00);
    on_battery = 1'b1;
    wr(3'd7, 8'h01);
    tick_at(8'h01, 8'h01, 8'h01, 8'h01, 8'h02, 1'b0);
    chk("R9 backup no bak_en irq", {7'd0, irq_n}, 8'h01);
    chk("R9 backup flag set", flags, 8'h40);
    clear_all();
    wr(3'd7, 8'h03);
    tick_at(8'h01, 8'h01, 8'h01, 8'h01, 8'h03, 1'b0);
    chk("R9 backup both enables irq", {7'd0, irq_n}, 8'h00);
    clear_all();
    wr(3'd7, 8'h02);
    tick_at(8'h01, 8'h01, 8'h01, 8'h01, 8'h04, 1'b0);
    chk("R9 backup bak_en only", {7'd0, irq_n}, 8'h01);
    clear_all();
    on_battery = 1'b0;
  endtask

  task automatic t_race();
    wr(3'd7, 8'h01);
    tick_at(8'h01, 8'h01, 8'h01, 8'h01, 8'h05, 1'b0);
    tick_at(8'h01, 8'h01, 8'h01, 8'h01, 8'h06, 1'b1);
    chk("R11 hit with release read irq", {7'd0, irq_n}, 8'h00);
    chk("R11 hit with release read flag", flags, 8'h40);
    rd_once();
    tick_at(8'h01, 8'h01, 8'h01, 8'h01, 8'h07, 1'b1);
    chk("R11 hit beats clear flag", flags, 8'h40);
    chk("R11 hit beats clear irq", {7'd0, irq_n}, 8'h00);
    clear_all();
    chk("R10 cleared after race", flags, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_exact();
    t_no_tick();
    t_repeat();
    t_fallback();
    t_enables();
    t_race();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule